// File: doc/BRIEF.md
# Interval Timer Bank

A bank of independent down-counting timer channels behind a small word-addressed register port. Each channel holds a control word, a programmed interval and a live count. It counts on strobes from one of two tick sources, thinned by a power-of-two prescaler. On each prescaled tick the count drops by one. When a tick finds the count at zero, the channel raises its pending flag. It then either reloads the interval and keeps running (continuous mode) or switches itself off (single-shot mode).

All channels share one interrupt-enable word and one write-one-to-clear status word. Bit n of each word belongs to channel n. An interrupt line is high while a channel's pending flag and its enable bit are both set. Software arms a channel in three steps: write the interval, set the run and reload bits, then wait for the line. Elapsed ticks can be read at any time from the live count. Because the counter runs down, elapsed time since a reload is the interval minus the live count.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every readable register reads 0 and every interrupt line is low.
- R2: Control bits 6:4 hold a prescale exponent k: a running channel makes one prescaled tick for every 2^k strobes of its selected source (k = 0 to 7).
- R3: Control bits 3:2 pick the tick source: value 2 uses `pll_tick_i`; values 0, 1 and 3 use `osc_tick_i`. A channel whose selected source is idle does not count.
- R4: Control bit 0 runs the channel. Control bit 1 requests a reload. With both set, the first prescaled tick copies the interval into the count, each later tick subtracts one, and the tick that finds the count at zero sets the pending flag. The first pending flag therefore comes interval+2 prescaled ticks after arming.
- R5: In continuous mode (control bit 7 = 0) the tick that finds zero reloads the interval, so pending events repeat every interval+1 prescaled ticks.
- R6: In single-shot mode (control bit 7 = 1) the tick that finds zero clears control bit 0 in hardware, and the count stays at 0.
- R7: Writing the status word at byte offset 0x04 clears each pending flag whose data bit is 1; data bits that are 0 leave their flags unchanged.
- R8: Interrupt line n equals pending flag n AND bit n of the enable word at byte offset 0x00. A masked channel still sets its pending flag.
- R9: The reload bit clears itself on the prescaled tick that performs the copy.
- R10: Channel n's control word is at byte offset 0x10+0x10·n, its interval at 0x14+0x10·n and its live count (read-only) at 0x18+0x10·n. Channels count and flag independently.
- R11: A channel with control bit 0 clear holds its live count unchanged.
- R12: A pending event in the same cycle as a clear of that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | Tick strobe of the primary source, one clock wide per tick |
| pll_tick_i | input | 1 | Tick strobe of the alternate source, one clock wide per tick |
| bus_we_i | input | 1 | Write strobe; the write commits on the clock edge |
| bus_addr_i | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| irq_o | output | NUM_CH | Per-channel interrupt lines |

## Verification
Every cycle, the assertions check the local counting rules. The live count drops by exactly one per tick, and the reload bit and the single-shot run bit clear themselves. A tick at zero always leaves its pending flag set, even against a clear. Pending flags stay set until software writes a clear, and an idle channel's count does not move. The prescale ratios, the source choice, the fallback source codes, the address map and the exact interrupt latency in clock cycles are end-to-end timings. Only the bench's scenarios can show those, by counting cycles from the arming write to the interrupt line. The same holds for the masking of interrupt lines by the enable word.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   // control word layout (fixed, software visible)
   localparam int unsigned CTRL_W = 8;
   localparam int unsigned PSC_W  = 3;

   typedef enum logic [1:0] {
      SRC_DFLT = 2'd0,
      SRC_OSC  = 2'd1,
      SRC_PLL  = 2'd2,
      SRC_SPARE = 2'd3
   } src_sel_e;

   typedef struct packed {
      logic             oneshot;  // bit 7
      logic [PSC_W-1:0] psc;      // bits 6:4
      src_sel_e         src;      // bits 3:2
      logic             reload;   // bit 1
      logic             enable;   // bit 0
   } ctrl_t;

   // word-address map
   localparam int unsigned IER_WORD       = 0;
   localparam int unsigned ISR_WORD       = 1;
   localparam int unsigned CH_BASE_WORD   = 4;
   localparam int unsigned CH_STRIDE_WORD = 4;
   localparam int unsigned CH_CTRL_OFS    = 0;
   localparam int unsigned CH_INTV_OFS    = 1;
   localparam int unsigned CH_CUR_OFS     = 2;

endpackage

// File: rtl/ttb_prescale.sv
module ttb_prescale
   import tick_timer_pkg::*;
#(
   parameter int unsigned PSC_BITS = PSC_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  src_sel_e            src,
   input  logic                osc_tick,
   input  logic                pll_tick,
   input  logic [PSC_BITS-1:0] psc,
   output logic                tick
);

   localparam int unsigned DIV_W = (1 << PSC_BITS) - 1;

   logic             src_tick;
   logic [DIV_W-1:0] pcnt;
   logic [DIV_W-1:0] limit;
   logic             wrap;

   // codes other than the alternate source fall back to the primary one
   always_comb begin
      src_tick = (src == SRC_PLL) ? pll_tick : osc_tick;
      limit    = ~({DIV_W{1'b1}} << psc);
      wrap     = (pcnt >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (!run) begin
         pcnt <= '0;
      end else if (src_tick) begin
         pcnt <= wrap ? '0 : pcnt + 1'b1;
      end
   end

   assign tick = run & src_tick & wrap;

endmodule

// File: rtl/ttb_chan.sv
module ttb_chan
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ctrl_we,
   input  ctrl_t            ctrl_wdata,
   input  logic             intv_we,
   input  logic [CNT_W-1:0] intv_wdata,
   output ctrl_t            ctrl_q,
   output logic [CNT_W-1:0] intv_q,
   output logic [CNT_W-1:0] cur_q,
   output logic             expire
);

   logic  at_zero;
   ctrl_t ctrl_hw;

   always_comb begin
      at_zero = (cur_q == '0);
      expire  = tick & ~ctrl_q.reload & at_zero;
      ctrl_hw = ctrl_q;
      if (tick && ctrl_q.reload) begin
         ctrl_hw.reload = 1'b0;
      end
      if (expire && ctrl_q.oneshot) begin
         ctrl_hw.enable = 1'b0;
      end
   end

   // bus write of the control word takes priority over hardware updates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         ctrl_q <= ctrl_we ? ctrl_wdata : ctrl_hw;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intv_q <= '0;
      end else if (intv_we) begin
         intv_q <= intv_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (tick) begin
         if (ctrl_q.reload) begin
            cur_q <= intv_q;
         end else if (at_zero) begin
            if (!ctrl_q.oneshot) begin
               cur_q <= intv_q;
            end
         end else begin
            cur_q <= cur_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
   import tick_timer_pkg::*;
#(
   parameter int unsigned NUM_CH  = 3,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter bit          REG_IRQ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick_i,
   input  logic              pll_tick_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic [NUM_CH-1:0] irq_o
);

   localparam int unsigned WA_W     = ADDR_W - 2;
   localparam int unsigned MAP_WORDS = CH_BASE_WORD + CH_STRIDE_WORD * NUM_CH;

   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_num_ch
      $error("NUM_CH must lie between 1 and DATA_W");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and DATA_W");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data_w
      $error("DATA_W too narrow for the control word");
   end
   if (ADDR_W < 3 || MAP_WORDS > (1 << WA_W)) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end

   logic [WA_W-1:0]   word;
   logic [NUM_CH-1:0] ier_q;
   logic [NUM_CH-1:0] isr_q;
   logic [NUM_CH-1:0] isr_clr;
   logic              ier_we;
   logic              isr_we;
   logic [NUM_CH-1:0] ctrl_we;
   logic [NUM_CH-1:0] tick_vec;
   logic [NUM_CH-1:0] expire_vec;
   ctrl_t             ctrl_q [NUM_CH];
   logic [CNT_W-1:0]  intv_q [NUM_CH];
   logic [CNT_W-1:0]  cur_q  [NUM_CH];
   logic              unused_bits;

   assign word        = bus_addr_i[ADDR_W-1:2];
   assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i};
   assign ier_we      = bus_we_i && (word == WA_W'(IER_WORD));
   assign isr_we      = bus_we_i && (word == WA_W'(ISR_WORD));
   assign isr_clr     = isr_we ? bus_wdata_i[NUM_CH-1:0] : '0;

   // per-channel datapath
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int unsigned CW = CH_BASE_WORD + CH_STRIDE_WORD * i;
      logic intv_we;

      assign ctrl_we[i] = bus_we_i && (word == WA_W'(CW + CH_CTRL_OFS));
      assign intv_we    = bus_we_i && (word == WA_W'(CW + CH_INTV_OFS));

      ttb_prescale #(
         .PSC_BITS (PSC_W)
      ) u_psc (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (ctrl_q[i].enable),
         .src      (ctrl_q[i].src),
         .osc_tick (osc_tick_i),
         .pll_tick (pll_tick_i),
         .psc      (ctrl_q[i].psc),
         .tick     (tick_vec[i])
      );

      ttb_chan #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tick_vec[i]),
         .ctrl_we    (ctrl_we[i]),
         .ctrl_wdata (ctrl_t'(bus_wdata_i[CTRL_W-1:0])),
         .intv_we    (intv_we),
         .intv_wdata (bus_wdata_i[CNT_W-1:0]),
         .ctrl_q     (ctrl_q[i]),
         .intv_q     (intv_q[i]),
         .cur_q      (cur_q[i]),
         .expire     (expire_vec[i])
      );
   end

   // shared enable and status words; a new event beats a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q <= '0;
         isr_q <= '0;
      end else begin
         if (ier_we) begin
            ier_q <= bus_wdata_i[NUM_CH-1:0];
         end
         isr_q <= (isr_q & ~isr_clr) | expire_vec;
      end
   end

   // read mux
   always_comb begin
      bus_rdata_o = '0;
      if (word == WA_W'(IER_WORD)) begin
         bus_rdata_o[NUM_CH-1:0] = ier_q;
      end else if (word == WA_W'(ISR_WORD)) begin
         bus_rdata_o[NUM_CH-1:0] = isr_q;
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (word == WA_W'(CH_BASE_WORD + CH_STRIDE_WORD * i + CH_CTRL_OFS)) begin
            bus_rdata_o[CTRL_W-1:0] = ctrl_q[i];
         end
         if (word == WA_W'(CH_BASE_WORD + CH_STRIDE_WORD * i + CH_INTV_OFS)) begin
            bus_rdata_o[CNT_W-1:0] = intv_q[i];
         end
         if (word == WA_W'(CH_BASE_WORD + CH_STRIDE_WORD * i + CH_CUR_OFS)) begin
            bus_rdata_o[CNT_W-1:0] = cur_q[i];
         end
      end
   end

   // interrupt lines: combinational or registered variant
   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_o <= '0;
         end else begin
            irq_o <= isr_q & ier_q;
         end
      end
   end else begin : g_irq_comb
      assign irq_o = isr_q & ier_q;
   end

endmodule

// File: rtl/ttb_checker.sv
module ttb_checker
   import tick_timer_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input ctrl_t             ctrl_q [NUM_CH],
   input logic [CNT_W-1:0]  intv_q [NUM_CH],
   input logic [CNT_W-1:0]  cur_q  [NUM_CH],
   input logic [NUM_CH-1:0] tick_vec,
   input logic [NUM_CH-1:0] ctrl_we,
   input logic [NUM_CH-1:0] isr_q,
   input logic              isr_we
);

   // R7: without a status write, no pending flag ever drops
   p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !isr_we |=> ((isr_q & $past(isr_q)) == $past(isr_q)))
      else $error("status flag dropped without a clear");

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_vec[i] && !ctrl_q[i].reload && cur_q[i] != '0)
         |=> (cur_q[i] == CNT_W'($past(cur_q[i]) - 1'b1)))
         else $error("count did not step down by one");

      // R12 as well: the flag is set even against a same-cycle clear
      p_pending_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_vec[i] && !ctrl_q[i].reload && cur_q[i] == '0) |=> isr_q[i])
         else $error("expiry did not set the pending flag");

      p_cont_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_vec[i] && !ctrl_q[i].reload && !ctrl_q[i].oneshot && cur_q[i] == '0)
         |=> (cur_q[i] == $past(intv_q[i])))
         else $error("continuous channel did not reload");

      p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_vec[i] && !ctrl_q[i].reload && ctrl_q[i].oneshot && cur_q[i] == '0
          && !ctrl_we[i]) |=> (!ctrl_q[i].enable && cur_q[i] == '0))
         else $error("single-shot channel kept running");

      p_reload_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_vec[i] && ctrl_q[i].reload && !ctrl_we[i]) |=> !ctrl_q[i].reload)
         else $error("reload request not cleared");

      p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_q[i].enable |=> $stable(cur_q[i]))
         else $error("idle channel count moved");
   end

endmodule

bind tick_timer_bank ttb_checker #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W)
) u_ttb_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_q   (ctrl_q),
   .intv_q   (intv_q),
   .cur_q    (cur_q),
   .tick_vec (tick_vec),
   .ctrl_we  (ctrl_we),
   .isr_q    (isr_q),
   .isr_we   (isr_we)
);

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/1ps
module test_tick_timer_bank;

   localparam logic [7:0] A_IER = 8'h00, A_ISR = 8'h04;
   localparam logic [7:0] A_CTRL0 = 8'h10, A_INTV0 = 8'h14, A_CUR0 = 8'h18;
   localparam logic [7:0] A_CUR1 = 8'h28;
   localparam logic [7:0] A_CTRL2 = 8'h30, A_INTV2 = 8'h34;

   // vector fields: {pll_on, osc_on, src_sel[1:0], k[2:0], interval[15:0]}
   localparam int NVEC = 8;
   localparam logic [22:0] VEC [NVEC] = '{
      {1'b0, 1'b1, 2'd1, 3'd0, 16'd5},
      {1'b0, 1'b1, 2'd1, 3'd2, 16'd3},
      {1'b1, 1'b0, 2'd2, 3'd1, 16'd4},
      {1'b0, 1'b1, 2'd0, 3'd0, 16'd2},
      {1'b0, 1'b1, 2'd3, 3'd3, 16'd1},
      {1'b1, 1'b0, 2'd1, 3'd0, 16'd2},
      {1'b0, 1'b1, 2'd2, 3'd0, 16'd2},
      {1'b0, 1'b1, 2'd1, 3'd7, 16'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc = 1'b0;
   logic        pll = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [2:0]  irq;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tick_timer_bank i_tick_timer_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .osc_tick_i  (osc),
      .pll_tick_i  (pll),
      .bus_we_i    (we),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1;
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   // edges after the arming write until irq bit b is high, 0 if never
   task automatic wait_irq(input int limit, input int b, output int n);
      n = 0;
      for (int c = 1; c <= limit; c++) begin
         @(posedge clk);
         #1;
         if (irq[b]) begin
            n = c;
            break;
         end
      end
   endtask

   // R2/R3/R4: (interval+2) prescaled ticks of 2^k edges, if the source runs
   function automatic int expect_edges(input logic [22:0] v);
      logic src_on;
      src_on = (v[20:19] == 2'd2) ? v[22] : v[21];
      return src_on ? ((int'(v[15:0]) + 2) << v[18:16]) : 0;
   endfunction

   initial begin
      #500000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int n;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(A_IER, r);   chk("R1 enable word", r, 0);
      rd(A_ISR, r);   chk("R1 status word", r, 0);
      rd(A_CTRL0, r); chk("R1 ctrl0", r, 0);
      rd(A_INTV0, r); chk("R1 interval0", r, 0);
      rd(A_CUR0, r);  chk("R1 count0", r, 0);
      rd(A_CTRL2, r); chk("R1 ctrl2", r, 0);
      chk("R1 irq lines", {29'b0, irq}, 0);

      wr(A_IER, 32'h7);

      // R2 R3 R4 vector table
      for (int v = 0; v < NVEC; v++) begin
         wr(A_CTRL0, 0);
         wr(A_ISR, 32'h1);
         wr(A_INTV0, {16'b0, VEC[v][15:0]});
         pll = VEC[v][22];
         osc = VEC[v][21];
         wr(A_CTRL0, {24'b0, 1'b0, VEC[v][18:16], VEC[v][20:19], 2'b11});
         wait_irq(300, 0, n);
         chk($sformatf("R2 R3 R4 vector %0d edges to irq", v), n, expect_edges(VEC[v]));
      end

      // R9 R4 R11: reload self-clear, countdown, hold when stopped
      pll = 1'b0; osc = 1'b1;
      wr(A_CTRL0, 0);
      wr(A_ISR, 32'h1);
      wr(A_INTV0, 100);
      wr(A_CTRL0, 32'h07);
      @(posedge clk);
      rd(A_CTRL0, r); chk("R9 reload bit cleared", r, 32'h05);
      repeat (9) @(posedge clk);
      rd(A_CUR0, r);  chk("R4 count after 10 edges", r, 91);
      wr(A_CTRL0, 0);
      repeat (5) @(posedge clk);
      rd(A_CUR0, r);  chk("R11 count held while stopped", r, 89);

      // R5 continuous: second event after interval edges from the clear edge
      wr(A_ISR, 32'h1);
      wr(A_INTV0, 3);
      wr(A_CTRL0, 32'h07);
      wait_irq(50, 0, n); chk("R5 first event", n, 5);
      wr(A_ISR, 32'h1);
      wait_irq(50, 0, n); chk("R5 repeat period", n, 3);
      rd(A_CUR0, r);      chk("R5 count reloaded", r, 3);

      // R6 single-shot
      wr(A_CTRL0, 0);
      wr(A_ISR, 32'h1);
      wr(A_INTV0, 2);
      wr(A_CTRL0, 32'h87);
      wait_irq(50, 0, n); chk("R6 single-shot event", n, 4);
      rd(A_CTRL0, r);     chk("R6 run bit cleared", r, 32'h84);
      repeat (5) @(posedge clk);
      rd(A_CUR0, r);      chk("R6 count stays zero", r, 0);
      rd(A_ISR, r);       chk("R6 one event only", r, 1);

      // R7 write-one-to-clear
      wr(A_ISR, 32'h0);
      rd(A_ISR, r);       chk("R7 zero write keeps flag", r, 1);
      wr(A_ISR, 32'h1);
      rd(A_ISR, r);       chk("R7 one write clears flag", r, 0);
      chk("R7 irq low after clear", {31'b0, irq[0]}, 0);

      // R8 masking
      wr(A_IER, 32'h0);
      wr(A_INTV0, 1);
      wr(A_CTRL0, 32'h07);
      repeat (6) @(posedge clk);
      rd(A_ISR, r);       chk("R8 masked flag still set", r, 1);
      chk("R8 masked irq low", {31'b0, irq[0]}, 0);
      wr(A_IER, 32'h7);
      chk("R8 unmasked irq high", {31'b0, irq[0]}, 1);

      // R12 event every edge against a clear
      wr(A_CTRL0, 0);
      wr(A_INTV0, 0);
      wr(A_CTRL0, 32'h07);
      repeat (4) @(posedge clk);
      wr(A_ISR, 32'h1);
      rd(A_ISR, r);       chk("R12 set wins over clear", r, 1);

      // R10 map and independence on channel 2
      wr(A_CTRL0, 0);
      wr(A_ISR, 32'h7);
      wr(A_INTV2, 1);
      wr(A_CTRL2, 32'h07);
      wait_irq(20, 2, n); chk("R10 channel 2 event", n, 3);
      chk("R10 only line 2", {29'b0, irq}, 32'h4);
      rd(A_ISR, r);       chk("R10 status bit 2", r, 32'h4);
      rd(A_CUR1, r);      chk("R10 channel 1 idle", r, 0);
      rd(A_INTV2, r);     chk("R10 channel 2 interval", r, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule